// File: doc/BRIEF.md
# Serial Flash Command Guard

This block sits between the opcode decoder of a serial NOR flash and its array sequencer. Each finished command arrives on a valid/ready interface as one beat: the decoded opcode, the target address, the number of serial clock edges counted while chip select was low, and the status byte used by a status write. The guard decides whether the command may run. It holds the write-enable latch, the status-lock bit, the four region-select bits and the power-down flag. It also reports which address window is currently read-only.

A handshake happens when `cmd_valid` and `cmd_ready` are both high on a rising edge. One cycle later `verdict_valid` pulses, and `verdict_accept` carries the decision. An accepted page program or erase raises `busy`. While `busy` is high, `cmd_ready` stays low, and the upstream decoder must hold its command until the array raises `op_done`. Status writes, latch commands and power-down commands take effect at the handshake edge itself. A power-up timer must expire before any command that changes data is taken.

Opcodes: 06h set latch, 04h clear latch, 01h status write, 02h page program, 20h sector erase, D8h block erase, C7h chip erase, B9h enter power-down, ABh leave power-down.

Top module: `flash_wp_guard`

## Requirements
- R1: A status write, page program, sector erase, block erase or chip erase whose edge count is not a multiple of eight is rejected, and the latch is left as it was.
- R2: Opcode 06h sets the latch. Any of the five modifying commands is rejected while the latch is clear.
- R3: The latch clears at reset, on an accepted 04h, on an accepted status write, and when `op_done` ends an accepted program or erase. A rejected command leaves the latch unchanged.
- R4: With region code `bp[2:0]` = 0 nothing is protected, and with 7 the whole array is protected. For a code n from 1 to 6, 2^(n-1) blocks are protected. They sit at the top of the array when `bp[3]`=0 and at the bottom when `bp[3]`=1. `prot_lo`/`prot_hi` give the inclusive byte bounds, and `prot_any` flags a non-empty window.
- R5: A program, sector erase or block erase whose address lies inside the window is rejected. A chip erase is rejected whenever `prot_any` is high.
- R6: An accepted status write loads `srp` from `cmd_sr[4]` and `bp` from `cmd_sr[3:0]`. While `wp_n` is low and `srp` is set, status writes are rejected and `srp`/`bp` do not change.
- R7: An accepted B9h sets `dpd`. While `dpd` is set, every command except ABh is rejected, and ABh clears `dpd`.
- R8: `pwr_ready` rises after `PUW_CYC` consecutive cycles with `pwr_ok` high. Before that, all five modifying commands are rejected.
- R9: `verdict_valid` pulses in the cycle after each handshake. `cmd_ready` is low while `busy` is high, from the accepting edge until the edge that samples `op_done`.
- R10: After reset, `wel`, `srp`, `bp`, `dpd`, `busy`, `verdict_valid` and `pwr_ready` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Supply within range; starts the power-up timer |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| cmd_valid | input | 1 | Command beat valid |
| cmd_ready | output | 1 | Guard can take a command |
| cmd_op | input | 8 | Decoded opcode |
| cmd_addr | input | AW | Target byte address |
| cmd_edges | input | EW | Clock edges counted under chip select |
| cmd_sr | input | 5 | Status value for a status write: lock bit 4, region bits 3:0 |
| verdict_valid | output | 1 | Decision pulse |
| verdict_accept | output | 1 | Command accepted |
| op_done | input | 1 | Array finished the accepted operation |
| busy | output | 1 | Array operation in progress |
| wel | output | 1 | Write-enable latch |
| srp | output | 1 | Status-lock bit |
| bp | output | 4 | Region-select bits |
| dpd | output | 1 | Deep power-down flag |
| pwr_ready | output | 1 | Power-up timer expired |
| prot_any | output | 1 | Protected window not empty |
| prot_lo | output | AW | Lowest protected address |
| prot_hi | output | AW | Highest protected address |

## Verification
The hardest state to reach is a rejection of a program or erase at each block edge for every region code, together with the proof that the rejection left the latch set. A block check of this kind takes a full status write, a latch set and a trial erase before it can be observed. The bench uses a 64-block array and sweeps all sixteen codes against every block. It sets the latch before each trial erase. After an accepted erase it completes the operation through `op_done`, and after a rejected one it reads the still-set latch back at the port before clearing it with 04h.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE   = 8'hC7;
  localparam logic [7:0] OP_DPD  = 8'hB9;
  localparam logic [7:0] OP_RDP  = 8'hAB;

  localparam int SR_W     = 5;
  localparam int SR_LOCK  = 4;

  typedef struct packed {
    logic accept;
    logic set_wel;
    logic clr_wel;
    logic wr_sr;
    logic start_op;
    logic enter_dpd;
    logic leave_dpd;
  } verdict_t;

  function automatic logic is_modifying(input logic [7:0] op);
    return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) ||
           (op == OP_BE) || (op == OP_CE);
  endfunction
endpackage

// File: rtl/wpg_pwrup.sv
module wpg_pwrup #(
  parameter int PUW_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok,
  output logic ready
);
  localparam int CW = $clog2(PUW_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(PUW_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!pwr_ok) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready = (cnt_q == LIMIT);
endmodule

// File: rtl/wpg_range.sv
module wpg_range #(
  parameter int AW     = 25,
  parameter int BLK_AW = 16
) (
  input  logic [3:0]    bp,
  output logic          any,
  output logic [AW-1:0] lo_addr,
  output logic [AW-1:0] hi_addr
);
  localparam int BW = AW - BLK_AW;

  logic [2:0]    code;
  logic          bottom;
  logic [BW:0]   cnt;
  logic [BW:0]   nblk;
  logic [BW-1:0] lo_blk;
  logic [BW-1:0] hi_blk;

  assign code   = bp[2:0];
  assign bottom = bp[3];
  assign nblk   = {1'b1, {BW{1'b0}}};

  always_comb begin
    cnt    = '0;
    lo_blk = '0;
    hi_blk = '0;
    any    = 1'b0;
    if (code == 3'd7) begin
      any    = 1'b1;
      lo_blk = '0;
      hi_blk = '1;
    end else if (code != 3'd0) begin
      any = 1'b1;
      cnt = {{BW{1'b0}}, 1'b1} << (code - 3'd1);
      if (bottom) begin
        lo_blk = '0;
        hi_blk = BW'(cnt - 1'b1);
      end else begin
        lo_blk = BW'(nblk - cnt);
        hi_blk = '1;
      end
    end
  end

  assign lo_addr = {lo_blk, {BLK_AW{1'b0}}};
  assign hi_addr = {hi_blk, {BLK_AW{1'b1}}};
endmodule

// File: rtl/wpg_policy.sv
module wpg_policy
  import wpg_pkg::*;
#(
  parameter int AW = 25,
  parameter int EW = 16
) (
  input  logic [7:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [EW-1:0] edges,
  input  logic          wel,
  input  logic          srp,
  input  logic          wp_n,
  input  logic          dpd,
  input  logic          pu_ready,
  input  logic          prot_any,
  input  logic [AW-1:0] prot_lo,
  input  logic [AW-1:0] prot_hi,
  output verdict_t      v
);
  logic aligned;
  logic gate;
  logic in_prot;
  logic sr_locked;

  assign aligned   = ((edges & EW'(7)) == '0);
  assign gate      = wel && aligned && pu_ready;
  assign in_prot   = prot_any && (addr >= prot_lo) && (addr <= prot_hi);
  assign sr_locked = !wp_n && srp;

  always_comb begin
    v = '0;
    if (dpd) begin
      if (op == OP_RDP) begin
        v.accept    = 1'b1;
        v.leave_dpd = 1'b1;
      end
    end else begin
      case (op)
        OP_WREN: begin
          v.accept  = 1'b1;
          v.set_wel = 1'b1;
        end
        OP_WRDI: begin
          v.accept  = 1'b1;
          v.clr_wel = 1'b1;
        end
        OP_DPD: begin
          v.accept    = 1'b1;
          v.enter_dpd = 1'b1;
        end
        OP_RDP: v.accept = 1'b1;
        OP_WRSR: begin
          if (gate && !sr_locked) begin
            v.accept  = 1'b1;
            v.wr_sr   = 1'b1;
            v.clr_wel = 1'b1;
          end
        end
        OP_PP, OP_SE, OP_BE: begin
          if (gate && !in_prot) begin
            v.accept   = 1'b1;
            v.start_op = 1'b1;
          end
        end
        OP_CE: begin
          if (gate && !prot_any) begin
            v.accept   = 1'b1;
            v.start_op = 1'b1;
          end
        end
        default: v = '0;
      endcase
    end
  end
endmodule

// File: rtl/flash_wp_guard.sv
module flash_wp_guard
  import wpg_pkg::*;
#(
  parameter int AW      = 25,
  parameter int BLK_AW  = 16,
  parameter int EW      = 16,
  parameter int PUW_CYC = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              wp_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [EW-1:0]     cmd_edges,
  input  logic [SR_W-1:0]   cmd_sr,
  output logic              verdict_valid,
  output logic              verdict_accept,
  input  logic              op_done,
  output logic              busy,
  output logic              wel,
  output logic              srp,
  output logic [3:0]        bp,
  output logic              dpd,
  output logic              pwr_ready,
  output logic              prot_any,
  output logic [AW-1:0]     prot_lo,
  output logic [AW-1:0]     prot_hi
);
  verdict_t v;
  logic     hs;

  wpg_pwrup #(.PUW_CYC(PUW_CYC)) u_pwrup (
    .clk   (clk),
    .rst_n (rst_n),
    .pwr_ok(pwr_ok),
    .ready (pwr_ready)
  );

  wpg_range #(.AW(AW), .BLK_AW(BLK_AW)) u_range (
    .bp     (bp),
    .any    (prot_any),
    .lo_addr(prot_lo),
    .hi_addr(prot_hi)
  );

  wpg_policy #(.AW(AW), .EW(EW)) u_policy (
    .op      (cmd_op),
    .addr    (cmd_addr),
    .edges   (cmd_edges),
    .wel     (wel),
    .srp     (srp),
    .wp_n    (wp_n),
    .dpd     (dpd),
    .pu_ready(pwr_ready),
    .prot_any(prot_any),
    .prot_lo (prot_lo),
    .prot_hi (prot_hi),
    .v       (v)
  );

  assign cmd_ready = !busy;
  assign hs        = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_valid  <= 1'b0;
      verdict_accept <= 1'b0;
      busy           <= 1'b0;
      wel            <= 1'b0;
      srp            <= 1'b0;
      bp             <= '0;
      dpd            <= 1'b0;
    end else begin
      verdict_valid <= hs;
      if (hs) begin
        verdict_accept <= v.accept;
      end
      if (busy && op_done) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else if (hs) begin
        if (v.set_wel) wel <= 1'b1;
        if (v.clr_wel) wel <= 1'b0;
        if (v.start_op) busy <= 1'b1;
        if (v.wr_sr) begin
          srp <= cmd_sr[SR_LOCK];
          bp  <= cmd_sr[3:0];
        end
        if (v.enter_dpd) dpd <= 1'b1;
        if (v.leave_dpd) dpd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wpg_checker.sv
module wpg_checker
  import wpg_pkg::*;
#(
  parameter int EW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wp_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [7:0]    cmd_op,
  input logic [EW-1:0] cmd_edges,
  input logic          verdict_valid,
  input logic          verdict_accept,
  input logic          op_done,
  input logic          busy,
  input logic          wel,
  input logic          srp,
  input logic [3:0]    bp,
  input logic          dpd,
  input logic          pwr_ready,
  input logic          prot_any
);
  logic hs;
  logic mod;
  assign hs  = cmd_valid && cmd_ready;
  assign mod = is_modifying(cmd_op);

  AST_BYTE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && mod && ((cmd_edges & EW'(7)) != '0)) |=> !verdict_accept); // R1
  AST_WEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && mod && !wel) |=> !verdict_accept); // R2
  AST_WEL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_done) |=> !wel); // R3
  AST_CE_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && (cmd_op == OP_CE) && prot_any) |=> !verdict_accept); // R5
  AST_SR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && srp) |=> ($stable(bp) && $stable(srp))); // R6
  AST_DPD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && dpd && (cmd_op != OP_RDP)) |=> !verdict_accept); // R7
  AST_PWRUP: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && mod && !pwr_ready) |=> !verdict_accept); // R8
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready); // R9
  AST_VERDICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> verdict_valid); // R9
endmodule

bind flash_wp_guard wpg_checker #(.EW(EW)) u_chk (.*);

// File: tb/sim_flash_wp_guard.sv
module sim_flash_wp_guard;
  localparam int AW = 10;
  localparam int BLK_AW = 4;
  localparam int EW = 8;
  localparam int PUW = 20;
  localparam int NB = 1 << (AW - BLK_AW);
  localparam int BS = 1 << BLK_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok = 1'b0;
  logic wp_n = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [7:0] cmd_op = 8'h00;
  logic [AW-1:0] cmd_addr = '0;
  logic [EW-1:0] cmd_edges = '0;
  logic [4:0] cmd_sr = '0;
  logic verdict_valid, verdict_accept;
  logic op_done = 1'b0;
  logic busy, wel, srp, dpd, pwr_ready, prot_any;
  logic [3:0] bp;
  logic [AW-1:0] prot_lo, prot_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_wp_guard #(.AW(AW), .BLK_AW(BLK_AW), .EW(EW), .PUW_CYC(PUW)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input int addr, input int edges,
                     input int sr, output bit acc);
    @(negedge clk);
    cmd_op = op; cmd_addr = AW'(addr); cmd_edges = EW'(edges);
    cmd_sr = 5'(sr); cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R9 verdict_valid", int'(verdict_valid), 1);
    acc = verdict_accept;
  endtask

  task automatic complete();
    chk("R9 ready low while busy", int'(cmd_ready), 0);
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
    chk("R9 busy cleared", int'(busy), 0);
    chk("R3 wel cleared on done", int'(wel), 0);
  endtask

  function automatic bit exp_prot(input int code, input int blk);
    int n, c;
    n = code & 7;
    if (n == 0) return 0;
    if (n == 7) return 1;
    c = 1 << (n - 1);
    if (code & 8) return blk < c;
    return blk >= NB - c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 wel", int'(wel), 0);
    chk("R10 bp", int'(bp), 0);
    chk("R10 srp", int'(srp), 0);
    chk("R10 dpd", int'(dpd), 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 verdict_valid", int'(verdict_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 pwr_ready", int'(pwr_ready), 0);

    // R8 before power-up timer
    cmd(8'h06, 0, 8, 0, a);
    chk("R2 wren accepted", int'(a), 1);
    chk("R2 wel set", int'(wel), 1);
    cmd(8'h01, 0, 16, 5'h03, a);
    chk("R8 early status write rejected", int'(a), 0);
    chk("R3 wel kept after reject", int'(wel), 1);
    chk("R8 bp unchanged", int'(bp), 0);
    pwr_ok = 1'b1;
    repeat (PUW - 2) @(negedge clk);
    chk("R8 timer not yet expired", int'(pwr_ready), 0);
    repeat (3) @(negedge clk);
    chk("R8 timer expired", int'(pwr_ready), 1);

    // R1 byte multiple
    cmd(8'h02, 5, 33, 0, a);
    chk("R1 odd edge count rejected", int'(a), 0);
    chk("R1 wel kept", int'(wel), 1);
    cmd(8'h02, 5, 40, 0, a);
    chk("R1 aligned program accepted", int'(a), 1);
    complete();
    cmd(8'h02, 5, 40, 0, a);
    chk("R2 program without wel rejected", int'(a), 0);

    // R4/R5 exhaustive sweep
    for (int code = 0; code < 16; code++) begin
      int n, c, elo, ehi;
      cmd(8'h06, 0, 8, 0, a);
      cmd(8'h01, 0, 16, code, a);
      chk("R6 status write accepted", int'(a), 1);
      chk("R6 bp loaded", int'(bp), code);
      chk("R3 wel cleared by status write", int'(wel), 0);
      n = code & 7;
      c = (n == 0) ? 0 : (1 << (n - 1));
      chk("R4 prot_any", int'(prot_any), (n != 0) ? 1 : 0);
      if (n == 7) begin elo = 0; ehi = NB * BS - 1; end
      else if (code & 8) begin elo = 0; ehi = c * BS - 1; end
      else begin elo = (NB - c) * BS; ehi = NB * BS - 1; end
      if (n != 0) begin
        chk("R4 prot_lo", int'(prot_lo), elo);
        chk("R4 prot_hi", int'(prot_hi), ehi);
      end
      for (int b = 0; b < NB; b++) begin
        bit e;
        e = exp_prot(code, b);
        cmd(8'h06, 0, 8, 0, a);
        cmd((b % 2) ? 8'h20 : 8'hD8, b * BS + (b % BS), 32, 0, a);
        chk("R5 erase verdict vs window", int'(a), e ? 0 : 1);
        if (a) complete();
        else begin
          chk("R3 wel kept after protected reject", int'(wel), 1);
          cmd(8'h04, 0, 8, 0, a);
          chk("R3 wel cleared by 04h", int'(wel), 0);
        end
      end
      cmd(8'h06, 0, 8, 0, a);
      cmd(8'hC7, 0, 8, 0, a);
      chk("R5 chip erase verdict", int'(a), (n != 0) ? 0 : 1);
      if (a) complete();
      else cmd(8'h04, 0, 8, 0, a);
    end

    // R6 hardware lock
    cmd(8'h06, 0, 8, 0, a);
    cmd(8'h01, 0, 8, 5'h13, a);
    chk("R6 lock bit loaded", int'(srp), 1);
    wp_n = 1'b0;
    cmd(8'h06, 0, 8, 0, a);
    cmd(8'h01, 0, 8, 5'h00, a);
    chk("R6 locked write rejected", int'(a), 0);
    chk("R6 bp held", int'(bp), 3);
    chk("R6 srp held", int'(srp), 1);
    wp_n = 1'b1;
    cmd(8'h01, 0, 8, 5'h00, a);
    chk("R6 unlocked write accepted", int'(a), 1);
    chk("R6 bp cleared", int'(bp), 0);

    // R7 power-down
    cmd(8'hB9, 0, 8, 0, a);
    chk("R7 enter", int'(dpd), 1);
    cmd(8'h06, 0, 8, 0, a);
    chk("R7 wren ignored", int'(a), 0);
    chk("R7 wel untouched", int'(wel), 0);
    cmd(8'hAB, 0, 8, 0, a);
    chk("R7 release accepted", int'(a), 1);
    chk("R7 dpd cleared", int'(dpd), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule